// File: doc/BRIEF.md
# Multi-hit TDC trigger matcher

This block sits behind a bank of multi-hit TDCs (64 channels per board) and in front of the readout link. Every time-stamped hit is written into a circular store as it arrives. The trigger reaches the block a fixed number of TDC counts after the physics event. On each trigger the block looks back at its store and collects every hit whose timestamp lies inside the acceptance window. Each collected hit is re-expressed as a channel number plus a time counted from the opening of that window. The hits are wrapped in a header and a trailer and queued as 32-bit words for the link.

The time base is the free-running TDC count `now_ts`, 26 bits wide, which wraps. All comparisons are modular, so a window may straddle the wrap point. Triggers that arrive while a frame is still being assembled wait in a small trigger queue. Overlapping windows each receive every hit they contain. Hits that no pending or future window can reach are retired, one per cycle, whenever the block is idle.

The hit input has no back-pressure, because a TDC cannot be stalled. A hit that finds the store full is dropped, and this is flagged in the next trailer. The output is a valid/ready stream. A word is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values. When the output FIFO is full, frame assembly pauses and no word is lost.

Top module: `tdc_trig_matcher`

## Requirements
- R1: After reset `out_valid` is low and the first frame carries frame number 0.
- R2: Every cycle with `hit_valid` high stores one hit (no stall). Matched hits leave in arrival order as `{channel[31:26], relative time[25:0]}`.
- R3: A trigger sampled high captures window start = `now_ts` − LATENCY (mod 2^26). A hit matches when (timestamp − start) mod 2^26 < WINDOW, and its relative time is that difference.
- R4: A frame is the board number word, then the frame number word, then `{6'b0, window start}`, then the hit records, then a trailer `{14'b0, lost bit 17, overflow bit 16, hit count[15:0]}`. `out_last` is high on the trailer only.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.
- R6: When two windows overlap, a hit inside both appears in both frames.
- R7: Matching and relative times are correct when the window, the hits or both straddle the timestamp wrap.
- R8: Retirement happens only while no frame is in progress and no trigger is queued. In that state the oldest stored hit is removed once it is earlier than `now_ts` − LATENCY, which frees its slot for new hits.
- R9: A hit arriving while BUF_DEPTH hits are stored is dropped. Bit 16 is set in the next trailer emitted, and the flag then clears.
- R10: The trigger queue holds TQ_DEPTH triggers. A trigger arriving while it is full produces no frame, and bit 17 is set in the next trailer emitted.
- R11: The frame number increments by one with each frame and wraps at 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_ts | input | 26 | Current TDC time count |
| hit_valid | input | 1 | A hit is presented this cycle |
| hit_chan | input | 6 | Channel of the hit |
| hit_time | input | 26 | Timestamp of the hit |
| trig_in | input | 1 | Trigger pulse, one cycle per trigger |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Frame word |
| out_last | output | 1 | Word is a frame trailer |

## Verification
The assertions rely on the following conditions on the inputs:
- Hit timestamps never decrease.
- Each hit arrives within LATENCY − WINDOW counts of its own time.
- LATENCY is at least WINDOW.
- No span of interest reaches 2^25 counts.

Under these conditions, a scan that meets a hit past the window end may stop, and modular differences never alias. The stimulus derives every timestamp from `now_ts` minus a jitter of at most two counts, with hits spaced far enough apart that the order is kept. The whole run is much shorter than half the timestamp range, even though it starts just below the wrap.

// File: rtl/tdcm_pkg.sv
package tdcm_pkg;
  localparam int CH_W   = 6;
  localparam int TS_W   = 26;
  localparam int WORD_W = CH_W + TS_W;
  localparam int CNT_W  = 16;

  typedef logic [TS_W-1:0] ts_t;

  typedef struct packed {
    logic [CH_W-1:0] ch;
    ts_t             ts;
  } hit_rec_t;

  typedef enum logic [2:0] {
    FS_IDLE, FS_HDR0, FS_HDR1, FS_HDR2, FS_SCAN, FS_TRL
  } fstate_e;

  // true when a lies strictly earlier than b on the modular time line
  function automatic logic ts_before(input ts_t a, input ts_t b);
    ts_t diff;
    diff = b - a;
    return (diff != '0) && !diff[TS_W-1];
  endfunction
endpackage

// File: rtl/tdcm_fifo.sv
module tdcm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign full  = (wp - rp) == (AW+1)'(DEPTH);
  assign empty = (wp == rp);
  assign rdata = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (rd) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp[AW-1:0]] <= wdata;
  end

  // R10
  fifo_no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !full);

  // R5
  fifo_no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> !empty);
endmodule

// File: rtl/tdcm_hit_buf.sv
module tdcm_hit_buf
  import tdcm_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = AW + 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  hit_rec_t wr_rec,
  input  logic     retire_ok,
  input  ts_t      guard_ts,
  input  logic [PW-1:0] scan_ptr,
  output hit_rec_t scan_rec,
  output logic [PW-1:0] head_ptr,
  output logic [PW-1:0] tail_ptr,
  output logic     full,
  output logic     retired
);
  hit_rec_t mem [DEPTH];
  logic     empty;
  hit_rec_t head_rec;

  assign full     = (tail_ptr - head_ptr) == PW'(DEPTH);
  assign empty    = (tail_ptr == head_ptr);
  assign head_rec = mem[head_ptr[AW-1:0]];
  assign scan_rec = mem[scan_ptr[AW-1:0]];
  assign retired  = retire_ok && !empty && ts_before(head_rec.ts, guard_ts);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      if (wr_en && !full) tail_ptr <= tail_ptr + 1'b1;
      if (retired)        head_ptr <= head_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[tail_ptr[AW-1:0]] <= wr_rec;
  end

  // R2
  hb_occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_ptr - head_ptr) <= PW'(DEPTH));
endmodule

// File: rtl/tdcm_framer.sv
module tdcm_framer
  import tdcm_pkg::*;
#(
  parameter logic [31:0] BOARD_ID = 32'h0000_0001,
  parameter int WINDOW = 10000,
  parameter int PW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tq_empty,
  input  ts_t           tq_start,
  output logic          tq_pop,
  input  logic [PW-1:0] head_ptr,
  input  logic [PW-1:0] tail_ptr,
  output logic [PW-1:0] scan_ptr,
  input  hit_rec_t      scan_rec,
  input  logic [1:0]    err_bits,
  input  logic          of_full,
  output logic          push,
  output logic [31:0]   push_word,
  output logic          push_last,
  output logic          busy
);
  fstate_e          st_q;
  ts_t              start_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      frame_id_q;
  ts_t              rel;
  logic             older, inwin, at_end;

  assign scan_ptr = scan_ptr_q;
  logic [PW-1:0] scan_ptr_q;
  assign busy = (st_q != FS_IDLE);

  always_comb begin
    rel       = scan_rec.ts - start_q;
    older     = rel[TS_W-1];
    inwin     = rel < TS_W'(WINDOW);
    at_end    = (scan_ptr_q == tail_ptr);
    tq_pop    = (st_q == FS_IDLE) && !tq_empty;
    push      = 1'b0;
    push_word = '0;
    push_last = 1'b0;
    unique case (st_q)
      FS_HDR0: begin push = !of_full; push_word = BOARD_ID; end
      FS_HDR1: begin push = !of_full; push_word = frame_id_q; end
      FS_HDR2: begin push = !of_full; push_word = {{(32-TS_W){1'b0}}, start_q}; end
      FS_SCAN: begin
        if (!at_end && !older && inwin) begin
          push      = !of_full;
          push_word = {scan_rec.ch, rel};
        end
      end
      FS_TRL: begin
        push      = !of_full;
        push_last = 1'b1;
        push_word = {14'b0, err_bits, cnt_q};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= FS_IDLE;
      start_q    <= '0;
      cnt_q      <= '0;
      frame_id_q <= '0;
      scan_ptr_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (tq_pop) begin
          start_q    <= tq_start;
          scan_ptr_q <= head_ptr;
          cnt_q      <= '0;
          st_q       <= FS_HDR0;
        end
        FS_HDR0: if (push) st_q <= FS_HDR1;
        FS_HDR1: if (push) st_q <= FS_HDR2;
        FS_HDR2: if (push) st_q <= FS_SCAN;
        FS_SCAN: begin
          if (at_end) st_q <= FS_TRL;
          else if (older) scan_ptr_q <= scan_ptr_q + 1'b1;
          else if (inwin) begin
            if (push) begin
              scan_ptr_q <= scan_ptr_q + 1'b1;
              cnt_q      <= cnt_q + 1'b1;
            end
          end else st_q <= FS_TRL;
        end
        FS_TRL: if (push) begin
          frame_id_q <= frame_id_q + 1'b1;
          st_q       <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  // R3
  win_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_SCAN && push) |-> (push_word[TS_W-1:0] < TS_W'(WINDOW)));
endmodule

// File: rtl/tdc_trig_matcher.sv
module tdc_trig_matcher
  import tdcm_pkg::*;
#(
  parameter logic [31:0] BOARD_ID = 32'h0000_0001,
  parameter int LATENCY   = 12000,
  parameter int WINDOW    = 10000,
  parameter int BUF_DEPTH = 64,
  parameter int TQ_DEPTH  = 4,
  parameter int OF_DEPTH  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [25:0] now_ts,
  input  logic        hit_valid,
  input  logic [5:0]  hit_chan,
  input  logic [25:0] hit_time,
  input  logic        trig_in,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last
);
  localparam int HB_AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int HB_PW = HB_AW + 1;

  ts_t              win_open;
  logic             tq_full, tq_empty, tq_pop, tq_wr;
  ts_t              tq_start;
  logic             hb_full, hb_retired;
  logic [HB_PW-1:0] head_ptr, tail_ptr, scan_ptr;
  hit_rec_t         scan_rec, new_rec;
  logic             fr_push, fr_last, fr_busy;
  logic [31:0]      fr_word;
  logic             of_full, of_empty;
  logic [32:0]      of_rdata;
  logic             ovf_pend, lost_pend, drop_hit, drop_trig, trl_push;

  assign win_open  = now_ts - TS_W'(LATENCY);
  assign tq_wr     = trig_in && !tq_full;
  assign drop_trig = trig_in && tq_full;
  assign drop_hit  = hit_valid && hb_full;
  assign new_rec   = '{ch: hit_chan, ts: hit_time};
  assign trl_push  = fr_push && fr_last;

  tdcm_fifo #(.W(TS_W), .DEPTH(TQ_DEPTH)) u_trig_q (
    .clk(clk), .rst_n(rst_n), .wr(tq_wr), .wdata(win_open),
    .rd(tq_pop), .rdata(tq_start), .full(tq_full), .empty(tq_empty)
  );

  tdcm_hit_buf #(.DEPTH(BUF_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(hit_valid), .wr_rec(new_rec),
    .retire_ok(!fr_busy && tq_empty), .guard_ts(win_open),
    .scan_ptr(scan_ptr), .scan_rec(scan_rec),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .full(hb_full), .retired(hb_retired)
  );

  tdcm_framer #(.BOARD_ID(BOARD_ID), .WINDOW(WINDOW), .PW(HB_PW)) u_framer (
    .clk(clk), .rst_n(rst_n), .tq_empty(tq_empty), .tq_start(tq_start),
    .tq_pop(tq_pop), .head_ptr(head_ptr), .tail_ptr(tail_ptr),
    .scan_ptr(scan_ptr), .scan_rec(scan_rec),
    .err_bits({lost_pend, ovf_pend}), .of_full(of_full),
    .push(fr_push), .push_word(fr_word), .push_last(fr_last), .busy(fr_busy)
  );

  tdcm_fifo #(.W(33), .DEPTH(OF_DEPTH)) u_out_q (
    .clk(clk), .rst_n(rst_n), .wr(fr_push), .wdata({fr_last, fr_word}),
    .rd(out_valid && out_ready), .rdata(of_rdata),
    .full(of_full), .empty(of_empty)
  );

  assign out_valid = !of_empty;
  assign out_data  = of_rdata[31:0];
  assign out_last  = of_rdata[32];

  // sticky error flags: a new event in the trailer cycle wins over the clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_pend  <= 1'b0;
      lost_pend <= 1'b0;
    end else begin
      if (trl_push) begin
        ovf_pend  <= drop_hit;
        lost_pend <= drop_trig;
      end else begin
        if (drop_hit)  ovf_pend  <= 1'b1;
        if (drop_trig) lost_pend <= 1'b1;
      end
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hb_full) |=> ovf_pend);

  // R8
  no_retire_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_busy || !tq_empty) |-> !hb_retired);
endmodule

// File: tb/sim_tdc_trig_matcher.sv
module sim_tdc_trig_matcher;
  localparam int LAT = 20;
  localparam int WIN = 8;
  localparam int BUFD = 64;
  localparam logic [31:0] BID = 32'h0000_5A17;
  localparam logic [25:0] T0 = 26'h3FF_FF00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [25:0] now_ts;
  logic hit_valid = 1'b0, trig_in = 1'b0, out_ready = 1'b0;
  logic [5:0]  hit_chan = '0;
  logic [25:0] hit_time = '0;
  logic out_valid, out_last;
  logic [31:0] out_data;
  logic [31:0] cyc = '0;

  int checks = 0, errors = 0;
  int rdy_mode = 0;
  bit finished = 0;

  logic [5:0]  hch [0:2047];
  logic [25:0] hts [0:2047];
  bit          hok [0:2047];
  int nh = 0;
  logic [25:0] tst [0:127];
  bit tok [0:127], tovf [0:127], tlost [0:127];
  string ttag [0:127];
  int nt = 0;
  logic [31:0] ow [0:8191];
  bit ol [0:8191];
  int nw = 0;

  tdc_trig_matcher #(.BOARD_ID(BID), .LATENCY(LAT), .WINDOW(WIN),
    .BUF_DEPTH(BUFD), .TQ_DEPTH(2), .OF_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .now_ts(now_ts), .hit_valid(hit_valid),
    .hit_chan(hit_chan), .hit_time(hit_time), .trig_in(trig_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign now_ts = T0 + cyc[25:0];

  always @(negedge clk) begin
    logic r;
    r = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ((cyc % 3) != 0) : 1'b0;
    out_ready = r;
    if (out_valid && r && nw < 8192) begin
      ow[nw] = out_data;
      ol[nw] = out_last;
      nw++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input bit h, input logic [5:0] ch, input int jit, input bit trg, input string tag);
    @(negedge clk);
    hit_valid = h;
    hit_chan  = ch;
    hit_time  = now_ts - 26'(jit);
    trig_in   = trg;
    if (h) begin
      hch[nh] = ch; hts[nh] = now_ts - 26'(jit); hok[nh] = 1; nh++;
    end
    if (trg) begin
      tst[nt] = now_ts - 26'(LAT); tok[nt] = 1; tovf[nt] = 0; tlost[nt] = 0;
      ttag[nt] = tag; nt++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 6'd0, 0, 0, "");
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    int p, fid, cnt, c0, d0, h0;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);

    // phase A: sparse hits, periodic triggers, time base crosses the wrap
    for (int i = 0; i < 450; i++)
      step(i % 3 == 0, 6'((i / 3) % 64), (i / 3) % 3, i % 37 == 36, "R7 wrap");
    idle(100);

    // phase B: overlapping trigger pairs, throttled output
    rdy_mode = 1;
    for (int i = 0; i < 400; i++)
      step(i % 2 == 0, 6'(63 - (i / 2) % 64), 0, (i % 100 == 50) || (i % 100 == 53), "R6 overlap");
    idle(150);

    // phase C: trigger queue saturation with output stalled
    rdy_mode = 2;
    for (int i = 0; i < 25; i++) step(i % 2 == 0, 6'(i), 0, 0, "");
    c0 = nt;
    for (int i = 0; i < 5; i++) step(1, 6'(40 + i), 0, 1, "R10 queue");
    tok[c0 + 3] = 0; tok[c0 + 4] = 0; tlost[c0] = 1;
    idle(10);
    held = out_data;
    idle(20);
    chk("R5 valid held under stall", {31'b0, out_valid}, 32'd1);
    chk("R5 data held under stall", out_data, held);
    for (int i = 0; i < 20; i++) step(i % 4 == 0, 6'(i), 0, 0, "");
    rdy_mode = 0;
    idle(200);

    // phase D: store overflow after the store has drained by retirement
    rdy_mode = 2;
    d0 = nt;
    step(0, 6'd0, 0, 1, "R4 empty frame");
    step(0, 6'd0, 0, 1, "R9 overflow flag");
    tovf[d0 + 1] = 1;
    h0 = nh;
    for (int i = 0; i < 70; i++) step(1, 6'(i % 64), 0, 0, "");
    for (int i = BUFD; i < 70; i++) hok[h0 + i] = 0;
    idle(8);
    step(0, 6'd0, 0, 1, "R8 R9 drained store");
    idle(20);
    rdy_mode = 0;
    idle(300);

    // compare the captured stream against the frames computed from the rules
    p = 0; fid = 0;
    for (int k = 0; k < nt; k++) begin
      if (!tok[k]) continue;
      if (p + 4 > nw) begin
        chk("R10 frame missing", 32'(nw), 32'(p + 4));
        break;
      end
      chk({"R4 board word ", ttag[k]}, ow[p], BID);
      chk({"R11 frame number ", ttag[k]}, ow[p + 1], 32'(fid));
      chk({"R3 window start ", ttag[k]}, ow[p + 2], {6'b0, tst[k]});
      chk("R4 header not last", {29'b0, ol[p], ol[p + 1], ol[p + 2]}, 32'd0);
      p += 3; cnt = 0;
      for (int h = 0; h < nh; h++) begin
        logic [25:0] dd;
        dd = hts[h] - tst[k];
        if (hok[h] && dd < 26'(WIN)) begin
          if (p < nw) chk({"R2 hit record ", ttag[k]}, ow[p], {hch[h], dd});
          else chk("R2 hit record missing", 32'(nw), 32'(p + 1));
          p++; cnt++;
        end
      end
      if (p < nw) begin
        chk({"R4 trailer ", ttag[k]}, ow[p],
            {14'b0, tlost[k], tovf[k], 16'(cnt)});
        chk("R4 trailer last", {31'b0, ol[p]}, 32'd1);
      end else chk("R4 trailer missing", 32'(nw), 32'(p + 1));
      p++; fid++;
    end
    chk("R5 total words transferred", 32'(nw), 32'(p));
    finished = 1;
    report();
  end
endmodule